// File: doc/BRIEF.md
# Multiphase Regulator Startup Sequencer

This block orders the power-up of a three-rail multiphase regulator controller. Once the supply is good, it holds every PWM output high-impedance for a fixed configuration window, so that strap values can be read. At the end of that window it records which phases are populated and captures the boot reference code. When enable goes high, every populated phase is placed in the diode-mode mid state. The external driver enable is asserted only after that, and only once the driver has released its hold line.

While the driver enable is high, a digital reference code climbs one step per external step tick from zero to the captured boot code. The step tick sets the soft-start rate. Each phase leaves the mid state on its own first modulator pulse and from then on follows its pulses. Dropping enable parks every populated phase in the mid state and clears the reference. Losing the supply returns the whole block to high-impedance and starts a new configuration window.

Phases are numbered from 0. Rail A takes the lowest indices, followed by rail B and then the single-phase rail. Phase 0 is the first phase of rail A.

Top module: `vr_startup_seq`

## Requirements
- R1: While `supply_ok` is low, and during the `CFG_CYCLES` cycles after it rises, every PWM code is 2'b11 (high-impedance), `drv_en` is 0, `ref_code` is 0 and `seq_done` is 0.
- R2: A phase whose `sense_high` bit is set at the end of the configuration window is disabled, and its PWM code stays 2'b11 until the next window. Changes to `sense_high` after the window have no effect.
- R3: Phase 0 is enabled regardless of its `sense_high` bit.
- R4: The first clock after `en` rises, every enabled phase shows 2'b10 (mid) and `drv_en` is 0. `drv_en` goes to 1 no earlier than the following clock.
- R5: While `drv_hold` is 1, the block stays in the mid state with `drv_en` at 0. It proceeds the clock after `drv_hold` clears.
- R6: With `drv_en` high, `ref_code` rises by exactly 1 on each clock where `step_tick` is 1 and never exceeds the boot code. `seq_done` goes to 1 the clock after `ref_code` reaches the boot code. A boot code of 0 gives `seq_done` one clock after `drv_en` rises.
- R7: During the ramp, an enabled phase shows 2'b10 until its first `pwm_pulse`. From that pulse on, it shows 2'b01 while the pulse is high and 2'b00 while it is low.
- R8: `pwm_pulse` bits of disabled phases are ignored, and those phases remain 2'b11.
- R9: When `en` falls after startup, the next clock shows every enabled phase at 2'b10, `drv_en` at 0, `ref_code` at 0 and `seq_done` at 0. A later rise of `en` restarts the sequence.
- R10: `boot_code` is captured at the end of the configuration window. Later changes, including across re-enables, have no effect on the ramp target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Controller supply is good |
| en | input | 1 | Enable for all rails |
| drv_hold | input | 1 | External driver holds its enable line low |
| sense_high | input | NPH | Per-phase current-sense input tied to the supply |
| boot_code | input | REF_W | Boot reference code from the strap reader |
| step_tick | input | 1 | Reference step clock-enable (sets the soft-start rate) |
| pwm_pulse | input | NPH | Per-phase modulator pulse |
| pwm_state | output | 2*NPH | Per-phase code: 00 low, 01 high, 10 mid, 11 high-impedance |
| drv_en | output | 1 | External driver enable |
| ref_code | output | REF_W | Digital reference code |
| seq_done | output | 1 | Reference has reached the boot code |

## Verification
A wrong population mask shows at the PWM codes on the first clock after enable: a phase is stuck at 2'b11 when it should be mid, or the reverse. A sequencer state that is out of step shows as `drv_en` rising together with the mid state, or rising while the hold line is set, within one clock. A corrupted reference counter or a lost boot capture shows as a skipped or repeated step, or as `seq_done` arriving at a code other than the captured target. A stale per-phase fired flag shows after a re-enable as a phase skipping the mid state.

// File: rtl/vr_startup_seq.sv
module vr_startup_seq #(
  parameter int PH_A       = 3,
  parameter int PH_B       = 3,
  parameter int PH_C       = 1,
  parameter int REF_W      = 8,
  parameter int CFG_CYCLES = 8,
  localparam int NPH       = PH_A + PH_B + PH_C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               supply_ok,
  input  logic               en,
  input  logic               drv_hold,
  input  logic [NPH-1:0]     sense_high,
  input  logic [REF_W-1:0]   boot_code,
  input  logic               step_tick,
  input  logic [NPH-1:0]     pwm_pulse,
  output logic [2*NPH-1:0]   pwm_state,
  output logic               drv_en,
  output logic [REF_W-1:0]   ref_code,
  output logic               seq_done
);
  localparam int CNT_W = $clog2(CFG_CYCLES + 1);
  localparam logic [1:0] PWM_LO = 2'b00, PWM_HI = 2'b01, PWM_MID = 2'b10, PWM_HIZ = 2'b11;

  typedef enum logic [2:0] {S_OFF, S_CFG, S_WAIT, S_MID, S_RAMP, S_RUN, S_PARK} st_t;

  st_t              st;
  logic [CNT_W-1:0] cfg_cnt;
  logic [NPH-1:0]   ph_en;
  logic [NPH-1:0]   fired;
  logic [REF_W-1:0] boot_q;
  logic [REF_W-1:0] ref_q;

  wire   live     = (st == S_RAMP) || (st == S_RUN);
  wire   hiz_all  = (st == S_OFF) || (st == S_CFG) || (st == S_WAIT);
  wire   at_boot  = (ref_q == boot_q);

  assign drv_en   = live;
  assign ref_code = ref_q;
  assign seq_done = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cfg_cnt <= '0;
      ph_en   <= '0;
      boot_q  <= '0;
      ref_q   <= '0;
      fired   <= '0;
    end else if (!supply_ok) begin
      st      <= S_OFF;
      cfg_cnt <= '0;
      ref_q   <= '0;
      fired   <= '0;
    end else begin
      case (st)
        S_OFF: begin
          st      <= S_CFG;
          cfg_cnt <= '0;
        end
        S_CFG: begin
          cfg_cnt <= cfg_cnt + 1'b1;
          if (cfg_cnt == CNT_W'(CFG_CYCLES - 1)) begin
            st     <= S_WAIT;
            ph_en  <= ~sense_high | NPH'(1);
            boot_q <= boot_code;
          end
        end
        S_WAIT, S_PARK: if (en) st <= S_MID;
        S_MID: begin
          if (!en)            st <= S_PARK;
          else if (!drv_hold) st <= S_RAMP;
        end
        S_RAMP: begin
          if (!en)            st <= S_PARK;
          else if (at_boot)   st <= S_RUN;
          else if (step_tick) ref_q <= ref_q + 1'b1;
        end
        S_RUN: if (!en) st <= S_PARK;
        default: st <= S_OFF;
      endcase
      if (live && en) fired <= fired | (pwm_pulse & ph_en);
      if (live && !en) begin
        ref_q <= '0;
        fired <= '0;
      end
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic [1:0] code;
    always_comb begin
      if (hiz_all || !ph_en[i])            code = PWM_HIZ;
      else if (!live)                      code = PWM_MID;
      else if (fired[i] || pwm_pulse[i])   code = pwm_pulse[i] ? PWM_HI : PWM_LO;
      else                                 code = PWM_MID;
    end
    assign pwm_state[2*i +: 2] = code;

    a_r7_no_return_to_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && $past(drv_en) && en && $past(pwm_state[2*i+1]) == 1'b0) |-> pwm_state[2*i+1] == 1'b0);
  end

  a_r1_hiz_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (pwm_state == {NPH{PWM_HIZ}}) && !drv_en && ref_code == '0);

  a_r3_phase0_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en || seq_done) |-> pwm_state[1:0] != PWM_HIZ);

  a_r4_drv_after_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(en) && $past(supply_ok) && !$past(drv_hold));

  a_r5_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && drv_hold) |=> !drv_en);

  a_r6_ref_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code != $past(ref_code)) |-> (ref_code == $past(ref_code) + 1'b1) || (ref_code == '0));

  a_r6_ref_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= boot_q);

  a_r9_disable_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !en) |=> !drv_en && !seq_done && ref_code == '0);
endmodule

// File: tb/tb_vr_startup_seq.sv
module tb_vr_startup_seq;
  localparam int NPH = 7;
  localparam int REF_W = 8;
  localparam int CFG = 8;

  logic clk = 0, rst_n = 0, supply_ok = 0, en = 0, drv_hold = 0, step_tick = 0;
  logic [NPH-1:0] sense_high = '0, pwm_pulse = '0;
  logic [REF_W-1:0] boot_code = '0;
  logic [2*NPH-1:0] pwm_state;
  logic drv_en, seq_done;
  logic [REF_W-1:0] ref_code;
  int checks = 0, fails = 0;

  vr_startup_seq dut (.clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en(en), .drv_hold(drv_hold),
    .sense_high(sense_high), .boot_code(boot_code), .step_tick(step_tick), .pwm_pulse(pwm_pulse),
    .pwm_state(pwm_state), .drv_en(drv_en), .ref_code(ref_code), .seq_done(seq_done));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*NPH-1:0] vec(input logic [NPH-1:0] mask, input logic [1:0] code);
    logic [2*NPH-1:0] v;
    for (int i = 0; i < NPH; i++) v[2*i +: 2] = mask[i] ? code : 2'b11;
    return v;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 reset pwm", 32'(pwm_state), 32'(vec('0, 2'b10)));
    chk("R1 reset drv/ref/done", {drv_en, seq_done, ref_code}, 0);
    rst_n = 1;
  endtask

  task automatic t_config(input logic [NPH-1:0] sense, input logic [REF_W-1:0] boot);
    sense_high = sense;
    boot_code = boot;
    supply_ok = 1;
    cyc(4);
    chk("R1 cfg window hiz", 32'(pwm_state), 32'(vec('0, 2'b10)));
    chk("R1 cfg window drv", drv_en, 0);
    cyc(CFG);
  endtask

  task automatic t_start(input logic [NPH-1:0] mask);
    drv_hold = 1;
    en = 1;
    cyc(1);
    chk("R4 mid on enable", 32'(pwm_state), 32'(vec(mask, 2'b10)));
    chk("R4 drv low with mid", drv_en, 0);
    cyc(4);
    chk("R5 held off drv", drv_en, 0);
    chk("R5 held off mid", 32'(pwm_state), 32'(vec(mask, 2'b10)));
    drv_hold = 0;
    cyc(1);
    chk("R5 release drv", drv_en, 1);
    chk("R6 ref starts 0", ref_code, 0);
  endtask

  task automatic t_ramp_pulses();
    step_tick = 1;
    cyc(2);
    chk("R6 two steps", ref_code, 2);
    step_tick = 0;
    pwm_pulse = 7'b0000110;
    cyc(1);
    chk("R6 no tick stable", ref_code, 2);
    chk("R7 phase1 high on pulse", 32'(pwm_state[3:2]), 1);
    chk("R7 phase3 still mid", 32'(pwm_state[7:6]), 2);
    chk("R8 disabled phase2 ignores pulse", 32'(pwm_state[5:4]), 3);
    pwm_pulse = '0;
    cyc(1);
    chk("R7 phase1 low after pulse", 32'(pwm_state[3:2]), 0);
    chk("R7 phase0 still mid", 32'(pwm_state[1:0]), 2);
    step_tick = 1;
    cyc(3);
    chk("R6 reached boot", ref_code, 5);
    chk("R6 done one clock later", seq_done, 0);
    cyc(1);
    chk("R6 done", seq_done, 1);
    cyc(2);
    chk("R6 ref bounded", ref_code, 5);
    step_tick = 0;
  endtask

  task automatic t_disable(input logic [NPH-1:0] mask);
    en = 0;
    cyc(1);
    chk("R9 park mid", 32'(pwm_state), 32'(vec(mask, 2'b10)));
    chk("R9 park drv/done/ref", {drv_en, seq_done, ref_code}, 0);
  endtask

  task automatic t_reenable();
    boot_code = 8'd20;
    sense_high = '0;
    en = 1;
    cyc(2);
    chk("R4 reenable drv", drv_en, 1);
    chk("R2 late sense ignored", 32'(pwm_state[5:4]), 3);
    step_tick = 1;
    cyc(6);
    chk("R10 target kept", ref_code, 5);
    chk("R10 done at old target", seq_done, 1);
    step_tick = 0;
  endtask

  task automatic t_supply_loss();
    supply_ok = 0;
    cyc(1);
    chk("R1 supply loss hiz", 32'(pwm_state), 32'(vec('0, 2'b10)));
    chk("R1 supply loss drv/ref", {drv_en, seq_done, ref_code}, 0);
    en = 0;
  endtask

  task automatic t_all_high_zero_boot();
    t_config('1, 8'd0);
    en = 1;
    cyc(1);
    chk("R3 phase0 mid only", 32'(pwm_state), 32'(vec(7'b0000001, 2'b10)));
    cyc(1);
    chk("R6 zero boot drv", {drv_en, seq_done}, 2'b10);
    cyc(1);
    chk("R6 zero boot done", {seq_done, ref_code}, 9'h100);
  endtask

  initial begin
    t_reset();
    t_config(7'b0100100, 8'd5);
    t_start(7'b1011011);
    t_ramp_pulses();
    t_disable(7'b1011011);
    t_reenable();
    t_supply_loss();
    t_all_high_zero_boot();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule